// File: doc/BRIEF.md
# Four-Phase Programmable Transmit FIR Equalizer

This block is the digital core of a high-speed serial transmitter. Each clock it takes in four new 4-level PAM symbols (2 bits each) and produces four signed output samples, one per output phase, for a downstream DAC multiplexer. Every output phase computes a 16-tap FIR sum over the recent symbol history. Each phase has its own bank of 16 signed 10-bit coefficients. With identical banks the datapath is a parallelized baseband equalizer. With different banks the same hardware acts as an over-sampled equalizer, a multi-tone transmultiplexer or a cyclically time-variant equalizer.

No multipliers are used. For every tap the block stores the coefficient W and its triple 3W. A four-way selector picks ±W or ±3W according to the symbol level. The sixteen selected products of a phase are reduced by three levels of 4-to-2 carry-save compressors. A registered carry/sum pair then feeds a final carry-propagate adder and the output register.

Coefficients are loaded through a single-cycle write port that gives a phase index, a tap index and a value. The triple is formed in the same cycle.

Top module: `txeq_polyphase`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `out_valid_o` is 0 and every output sample is 0. Reset clears all coefficients to 0 and fills the symbol history with code 00.
- R2: Symbol codes map to levels as follows: 00 → −3, 01 → −1, 10 → +1, 11 → +3. A tap contributes level × coefficient.
- R3: Lane i of `sym_i` occupies bits [2i+1:2i], and lane 0 is the earliest symbol of the group. Output phase p occupies bits [16p+15:16p] of `out_o`. Phase p applies tap 0 to lane p of the newest group and applies tap k to the symbol k positions earlier in serial order.
- R4: Each phase uses only its own coefficient bank. The four samples of one cycle may therefore follow four different impulse responses.
- R5: An output group appears with `out_valid_o` high exactly 2 clock edges after the edge that accepts its symbols. When `out_valid_o` is low, `out_o` holds its previous value.
- R6: A write with `cfg_we_i` high stores `cfg_coef_i` (signed) at phase `cfg_phase_i`, tap `cfg_tap_i`, and leaves all other taps unchanged. The new value, and its triple, apply to symbols accepted on the same clock edge as the write.
- R7: The symbol history advances by four only on cycles with `sym_valid_i` high. Idle cycles leave it unchanged.
- R8: Outputs are signed 16-bit values and never wrap. All taps at −512 with all symbols +3 gives −24576. All taps at 511 with all symbols −3 gives −24528.
- R9: When all four banks hold the same coefficients, the four phases together equal a serial 16-tap FIR applied to the symbol stream taken in lane order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Coefficient write strobe |
| cfg_phase_i | input | 2 | Phase bank addressed by the write |
| cfg_tap_i | input | 4 | Tap index addressed by the write |
| cfg_coef_i | input | 10 | Signed coefficient value |
| sym_valid_i | input | 1 | Four new symbols present on `sym_i` |
| sym_i | input | 8 | Four 2-bit symbols, lane 0 in the low bits |
| out_valid_o | output | 1 | Output group valid |
| out_o | output | 64 | Four signed 16-bit samples, phase 0 in the low bits |

## Verification
A coefficient write and a symbol group can land on the same clock edge, so the bench must settle which taps that group sees. The bench streams symbols continuously and writes a different phase and tap on every edge of the stream. Its reference model applies each write before it evaluates the group accepted on that edge. Every output sample is compared against that model, which tells an off-by-one-cycle coefficient update apart from the correct one.

// File: rtl/txeq_pkg.sv
`timescale 1ns/1ps
package txeq_pkg;
    // 2-bit PAM symbol code
    typedef logic [1:0] sym_t;

    localparam sym_t SYM_NEG3 = 2'b00;
    localparam sym_t SYM_NEG1 = 2'b01;
    localparam sym_t SYM_POS1 = 2'b10;
    localparam sym_t SYM_POS3 = 2'b11;
endpackage

// File: rtl/txeq_csa42.sv
`timescale 1ns/1ps
// Vector 4-to-2 carry-save compressor built from two 3:2 layers.
// The sum of the outputs equals a+b+c+d modulo 2^W.
module txeq_csa42 #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic [W-1:0] d,
    output logic [W-1:0] s,
    output logic [W-1:0] cy
);
    logic [W-1:0] s1;
    logic [W-1:0] c1;
    logic [W-1:0] maj2;

    always_comb begin
        s1   = a ^ b ^ c;
        c1   = {((a[W-2:0] & b[W-2:0]) | (a[W-2:0] & c[W-2:0]) | (b[W-2:0] & c[W-2:0])), 1'b0};
        s    = s1 ^ c1 ^ d;
        maj2 = (s1 & c1) | (s1 & d) | (c1 & d);
        cy   = {maj2[W-2:0], 1'b0};
    end
endmodule

// File: rtl/txeq_coef_bank.sv
`timescale 1ns/1ps
// Coefficient storage: W and 3W for every tap of every phase.
module txeq_coef_bank #(
    parameter int NPH  = 4,
    parameter int NTAP = 16,
    parameter int CW   = 10,
    localparam int PW  = $clog2(NPH),
    localparam int TW  = $clog2(NTAP)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  we_i,
    input  logic [PW-1:0]                         phase_i,
    input  logic [TW-1:0]                         tap_i,
    input  logic [CW-1:0]                         coef_i,
    output logic [NPH-1:0][NTAP-1:0][CW-1:0]      w_o,
    output logic [NPH-1:0][NTAP-1:0][CW+1:0]      w3_o
);
    typedef struct packed {
        logic [NPH-1:0][NTAP-1:0][CW-1:0] w;
        logic [NPH-1:0][NTAP-1:0][CW+1:0] w3;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [CW+1:0] coef_ext;

    always_comb begin
        bank_d   = bank_q;
        coef_ext = {{2{coef_i[CW-1]}}, coef_i};
        if (we_i) begin
            bank_d.w[phase_i][tap_i]  = coef_i;
            bank_d.w3[phase_i][tap_i] = {coef_ext[CW:0], 1'b0} + coef_ext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign w_o  = bank_q.w;
    assign w3_o = bank_q.w3;
endmodule

// File: rtl/txeq_phase_mac.sv
`timescale 1ns/1ps
// One output phase: per-tap product selection plus a 4:2 compressor tree.
// Result is left in carry-save form (sum_o + cry_o).
module txeq_phase_mac
    import txeq_pkg::*;
#(
    parameter int NTAP = 16,
    parameter int CW   = 10,
    parameter int OW   = 16,
    localparam int LV    = $clog2(NTAP) - 1,
    localparam int NODES = 2 * NTAP - 2
) (
    input  logic [NTAP-1:0][CW-1:0] w_i,
    input  logic [NTAP-1:0][CW+1:0] w3_i,
    input  logic [NTAP-1:0][1:0]    sym_i,
    output logic [OW-1:0]           sum_o,
    output logic [OW-1:0]           cry_o
);
    // Offset of the first vector of tree level l in the flat node array
    function automatic int lvl_off(input int l);
        return 2 * NTAP - ((2 * NTAP) >> l);
    endfunction

    logic [OW-1:0] node [NODES];

    for (genvar k = 0; k < NTAP; k++) begin : g_sel
        logic [OW-1:0] pw;
        logic [OW-1:0] p3;
        logic [OW-1:0] pick;
        assign pw = {{(OW-CW){w_i[k][CW-1]}}, w_i[k]};
        assign p3 = {{(OW-CW-2){w3_i[k][CW+1]}}, w3_i[k]};
        always_comb begin
            unique case (sym_t'(sym_i[k]))
                SYM_POS3: pick = p3;
                SYM_POS1: pick = pw;
                SYM_NEG1: pick = '0 - pw;
                default:  pick = '0 - p3;
            endcase
        end
        assign node[k] = pick;
    end

    for (genvar l = 0; l < LV; l++) begin : g_lvl
        localparam int NIN = NTAP >> l;
        localparam int IB  = lvl_off(l);
        localparam int OB  = lvl_off(l + 1);
        for (genvar c = 0; c < NIN / 4; c++) begin : g_cmp
            txeq_csa42 #(.W(OW)) u_cmp (
                .a  (node[IB + 4*c]),
                .b  (node[IB + 4*c + 1]),
                .c  (node[IB + 4*c + 2]),
                .d  (node[IB + 4*c + 3]),
                .s  (node[OB + 2*c]),
                .cy (node[OB + 2*c + 1])
            );
        end
    end

    assign sum_o = node[NODES-2];
    assign cry_o = node[NODES-1];
endmodule

// File: rtl/txeq_polyphase.sv
`timescale 1ns/1ps
// Four-phase programmable transmit FIR equalizer (top).
module txeq_polyphase #(
    parameter int NPH  = 4,
    parameter int NTAP = 16,
    parameter int CW   = 10,
    parameter int OW   = 16,
    localparam int SW  = 2,
    localparam int WIN = NTAP + NPH - 1,
    localparam int PW  = $clog2(NPH),
    localparam int TW  = $clog2(NTAP)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we_i,
    input  logic [PW-1:0]       cfg_phase_i,
    input  logic [TW-1:0]       cfg_tap_i,
    input  logic [CW-1:0]       cfg_coef_i,
    input  logic                sym_valid_i,
    input  logic [NPH*SW-1:0]   sym_i,
    output logic                out_valid_o,
    output logic [NPH*OW-1:0]   out_o
);
    typedef struct packed {
        logic [WIN-1:0][SW-1:0] win;   // index WIN-1 is the newest symbol
        logic                   vld_a; // window freshly loaded
        logic [NPH-1:0][OW-1:0] sum;
        logic [NPH-1:0][OW-1:0] cry;
        logic                   vld_b; // carry-save pair loaded
        logic [NPH-1:0][OW-1:0] res;
        logic                   vld_c; // result loaded
    } pipe_t;

    pipe_t st_d, st_q;

    logic [NPH-1:0][NTAP-1:0][CW-1:0] w_all;
    logic [NPH-1:0][NTAP-1:0][CW+1:0] w3_all;
    logic [NTAP-1:0][SW-1:0]          ph_sym [NPH];
    logic [OW-1:0]                    ph_sum [NPH];
    logic [OW-1:0]                    ph_cry [NPH];

    txeq_coef_bank #(.NPH(NPH), .NTAP(NTAP), .CW(CW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .phase_i (cfg_phase_i),
        .tap_i   (cfg_tap_i),
        .coef_i  (cfg_coef_i),
        .w_o     (w_all),
        .w3_o    (w3_all)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        for (genvar k = 0; k < NTAP; k++) begin : g_tap
            assign ph_sym[p][k] = st_q.win[NTAP - 1 + p - k];
        end
        txeq_phase_mac #(.NTAP(NTAP), .CW(CW), .OW(OW)) u_mac (
            .w_i   (w_all[p]),
            .w3_i  (w3_all[p]),
            .sym_i (ph_sym[p]),
            .sum_o (ph_sum[p]),
            .cry_o (ph_cry[p])
        );
    end

    always_comb begin
        st_d = st_q;
        // stage A: symbol window
        st_d.vld_a = sym_valid_i;
        if (sym_valid_i) begin
            for (int j = 0; j < WIN - NPH; j++) st_d.win[j] = st_q.win[j + NPH];
            for (int i = 0; i < NPH; i++)       st_d.win[WIN - NPH + i] = sym_i[i*SW +: SW];
        end
        // stage B: compressed carry-save pair
        st_d.vld_b = st_q.vld_a;
        if (st_q.vld_a) begin
            for (int p = 0; p < NPH; p++) begin
                st_d.sum[p] = ph_sum[p];
                st_d.cry[p] = ph_cry[p];
            end
        end
        // stage C: carry-propagate add
        st_d.vld_c = st_q.vld_b;
        if (st_q.vld_b) begin
            for (int p = 0; p < NPH; p++) st_d.res[p] = st_q.sum[p] + st_q.cry[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid_o = st_q.vld_c;
    assign out_o       = st_q.res;
endmodule

// File: rtl/txeq_polyphase_chk.sv
`timescale 1ns/1ps
module txeq_polyphase_chk #(
    parameter int NPH  = 4,
    parameter int NTAP = 16,
    parameter int CW   = 10,
    parameter int OW   = 16,
    localparam int BOUND = NTAP * 3 * (1 << (CW - 1))
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sym_valid_i,
    input logic              out_valid_o,
    input logic [NPH*OW-1:0] out_o
);
    logic [2:0] vpipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vpipe_q <= '0;
        else        vpipe_q <= {vpipe_q[1:0], sym_valid_i};
    end

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!out_valid_o && out_o == '0));

    // R5
    out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o == vpipe_q[2]);

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> $stable(out_o));

    for (genvar p = 0; p < NPH; p++) begin : g_rng
        // R8
        no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid_o |-> ($signed(out_o[p*OW +: OW]) >= -BOUND &&
                             $signed(out_o[p*OW +: OW]) <=  BOUND));
    end
endmodule

bind txeq_polyphase txeq_polyphase_chk #(
    .NPH(NPH), .NTAP(NTAP), .CW(CW), .OW(OW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sym_valid_i (sym_valid_i),
    .out_valid_o (out_valid_o),
    .out_o       (out_o)
);

// File: tb/txeq_polyphase_test.sv
`timescale 1ns/1ps
module txeq_polyphase_test;
    localparam int NPH = 4, NTAP = 16, CW = 10, OW = 16, WIN = NTAP + NPH - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we_i = 1'b0;
    logic [1:0]        cfg_phase_i = '0;
    logic [3:0]        cfg_tap_i = '0;
    logic [CW-1:0]     cfg_coef_i = '0;
    logic              sym_valid_i = 1'b0;
    logic [NPH*2-1:0]  sym_i = '0;
    logic              out_valid_o;
    logic [NPH*OW-1:0] out_o;

    always #2.5 clk = ~clk;

    txeq_polyphase uut (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_phase_i(cfg_phase_i),
        .cfg_tap_i(cfg_tap_i), .cfg_coef_i(cfg_coef_i), .sym_valid_i(sym_valid_i),
        .sym_i(sym_i), .out_valid_o(out_valid_o), .out_o(out_o)
    );

    int         tap_m [NPH][NTAP];
    logic [1:0] hist [WIN];
    int         ser [$];
    int         eq [$];
    int         cq [$];
    string      tq [$];
    int         cyc = 0, n_chk = 0, n_fail = 0, seed = 7;
    logic [NPH*OW-1:0] last_out = '0;

    function automatic int lvl(input logic [1:0] c);
        case (c)
            2'b00:   return -3;
            2'b01:   return -1;
            2'b10:   return 1;
            default: return 3;
        endcase
    endfunction

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 16) & 32'h7fff;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock of stimulus; reference model updated in the same step.
    task automatic step(input bit v, input logic [7:0] s, input bit we = 0,
                        input int wp = 0, input int wt = 0, input int wv = 0,
                        input string tag = "R3", input bit serial = 0);
        int e;
        @(negedge clk);
        sym_valid_i = v;  sym_i = s;
        cfg_we_i = we;    cfg_phase_i = wp[1:0]; cfg_tap_i = wt[3:0]; cfg_coef_i = wv[CW-1:0];
        if (we) tap_m[wp][wt] = wv;
        if (v) begin
            for (int j = 0; j < WIN - NPH; j++) hist[j] = hist[j + NPH];
            for (int i = 0; i < NPH; i++) begin
                hist[WIN - NPH + i] = s[2*i +: 2];
                ser.push_back(lvl(s[2*i +: 2]));
            end
            for (int p = 0; p < NPH; p++) begin
                e = 0;
                for (int k = 0; k < NTAP; k++) begin
                    if (serial) e += tap_m[0][k] * ser[ser.size() - NPH + p - k];
                    else        e += tap_m[p][k] * lvl(hist[NTAP - 1 + p - k]);
                end
                eq.push_back(e);
            end
            cq.push_back(cyc);
            tq.push_back(tag);
        end
    endtask

    task automatic write_tap(input int p, input int t, input int v);
        step(0, 8'h00, 1, p, t, v);
    endtask

    task automatic drain();
        repeat (5) step(0, 8'h00);
        check(cq.size() == 0, "R5 all groups delivered", cq.size(), 0);
    endtask

    task automatic clear_taps();
        for (int p = 0; p < NPH; p++)
            for (int t = 0; t < NTAP; t++) write_tap(p, t, 0);
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Output monitor: compares every valid group, checks hold while idle
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid_o) begin
                if (cq.size() == 0) begin
                    check(0, "R5 unexpected valid", 1, 0);
                end else begin
                    int c;
                    string tg;
                    c  = cq.pop_front();
                    tg = tq.pop_front();
                    check(cyc == c + 3, "R5 latency", cyc, c + 3);
                    for (int p = 0; p < NPH; p++) begin
                        int a, x;
                        a = int'($signed(out_o[p*OW +: OW]));
                        x = eq.pop_front();
                        check(a == x, tg, a, x);
                    end
                end
            end else begin
                check(out_o == last_out, "R5 hold while idle", int'(out_o[31:0]), int'(last_out[31:0]));
                if (cq.size() > 0)
                    check(cyc <= cq[0] + 3, "R5 missing valid", cyc, cq[0] + 3);
            end
            last_out = out_o;
        end
    end

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(out_valid_o == 1'b0, "R1 valid low in reset", int'(out_valid_o), 0);
        check(out_o == '0, "R1 outputs zero in reset", int'(out_o[31:0]), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid_o == 1'b0, "R1 valid low after release", int'(out_valid_o), 0);
        check(out_o == '0, "R1 outputs zero after release", int'(out_o[31:0]), 0);
    endtask

    task automatic t_encoding();
        write_tap(0, 0, 100);
        write_tap(2, 0, -37);
        step(1, {2'b11, 2'b10, 2'b01, 2'b00}, 0, 0, 0, 0, "R2");
        step(1, {2'b00, 2'b01, 2'b10, 2'b11}, 0, 0, 0, 0, "R2");
        step(1, {2'b10, 2'b11, 2'b00, 2'b01}, 0, 0, 0, 0, "R2");
        drain();
        clear_taps();
    endtask

    task automatic t_ordering();
        for (int p = 0; p < NPH; p++) write_tap(p, 1, 10 * (p + 1));
        write_tap(3, 15, 200);
        for (int n = 0; n < 8; n++) step(1, 8'(rnd()), 0, 0, 0, 0, "R3");
        drain();
        clear_taps();
    endtask

    task automatic t_independent();
        for (int p = 0; p < NPH; p++)
            for (int t = 0; t < NTAP; t++) write_tap(p, t, (rnd() % 1024) - 512);
        for (int n = 0; n < 12; n++) step(1, 8'(rnd()), 0, 0, 0, 0, "R4");
        drain();
    endtask

    task automatic t_baseband();
        int h [NTAP];
        for (int t = 0; t < NTAP; t++) h[t] = (rnd() % 1024) - 512;
        for (int p = 0; p < NPH; p++)
            for (int t = 0; t < NTAP; t++) write_tap(p, t, h[t]);
        for (int n = 0; n < 10; n++) step(1, 8'(rnd()), 0, 0, 0, 0, "R9", 1);
        drain();
    endtask

    task automatic t_idle_gaps();
        step(1, 8'h1b, 0, 0, 0, 0, "R7");
        repeat (4) step(0, 8'hff);
        step(1, 8'he4, 0, 0, 0, 0, "R7");
        step(0, 8'h55);
        step(0, 8'haa);
        step(1, 8'h72, 0, 0, 0, 0, "R7");
        step(1, 8'h8d, 0, 0, 0, 0, "R7");
        drain();
    endtask

    task automatic t_concurrent();
        for (int n = 0; n < 16; n++)
            step(1, 8'(rnd()), 1, n % NPH, (n * 5) % NTAP, (rnd() % 1024) - 512, "R6");
        write_tap(1, 7, 333);
        step(1, 8'(rnd()), 0, 0, 0, 0, "R6");
        step(1, 8'(rnd()), 0, 0, 0, 0, "R6");
        drain();
    endtask

    task automatic t_extremes();
        for (int p = 0; p < NPH; p++)
            for (int t = 0; t < NTAP; t++) write_tap(p, t, -512);
        repeat (5) step(1, 8'hff, 0, 0, 0, 0, "R8");
        drain();
        check(eq.size() == 0, "R8 queue empty", eq.size(), 0);
        check(int'($signed(out_o[OW-1:0])) == -24576, "R8 min extreme",
              int'($signed(out_o[OW-1:0])), -24576);
        for (int p = 0; p < NPH; p++)
            for (int t = 0; t < NTAP; t++) write_tap(p, t, 511);
        repeat (5) step(1, 8'h00, 0, 0, 0, 0, "R8");
        drain();
        check(int'($signed(out_o[4*OW-1:3*OW])) == -24528, "R8 max-tap extreme",
              int'($signed(out_o[4*OW-1:3*OW])), -24528);
    endtask

    initial begin
        for (int p = 0; p < NPH; p++)
            for (int t = 0; t < NTAP; t++) tap_m[p][t] = 0;
        for (int j = 0; j < WIN; j++) hist[j] = 2'b00;
        for (int j = 0; j < NTAP - 1; j++) ser.push_back(-3);
        t_reset();
        t_encoding();
        t_ordering();
        t_independent();
        t_idle_gaps();
        t_baseband();
        t_concurrent();
        t_extremes();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule